// File: doc/BRIEF.md
# AES-128 Round-Key Pipeline Stage

This block derives the next AES-128 round key from the current round key and an 8-bit round constant. It is one slice of a fully unrolled encryption pipeline. The key work is split into three registered sub-steps, so the key moves forward in lockstep with a data block passing through a round's substitution, row-shift and column-mix stages. The round key is therefore ready when that block reaches its key-addition stage. Each data block carries its own key, and a new key may enter on every clock, so back-to-back blocks can use unrelated keys.

The three sub-steps run in a fixed order:

- **Substitution.** Four byte-substitution units replace each byte of the last word of the current key.
- **Rotation.** The substituted word is rotated left by one byte, and the round constant is folded into its most significant byte.
- **XOR chain.** Four 32-bit GF(2) additions produce the new words one after another.

A valid flag travels with the data through every register. The flags are the only state that reset clears.

This is a fixed pipeline with no control state machine. Its three register ranks act as three named phases:

- SUB holds the current key with the substituted word.
- ROT holds the current key with the transformed word.
- XOR holds the finished key.

Every cycle, each rank's contents move to the next rank. The top module is shown below.

Top module: `aes128_key_step`

## Requirements
- R1: While `rst_n` is low, and until an accepted key has reached the output, `out_valid` is 0.
- R2: A key captured on a rising edge with `in_valid` high appears on `out_key`, with `out_valid` high, exactly three rising edges later.
- R3: Output word 0 equals input word 0 XOR T. T is the transformed word: the substituted last word of the input, rotated, with the round constant added. Word 0 is `key[127:96]`, word 3 is `key[31:0]`, and the first byte of each word is its bits [31:24].
- R4: For i = 1, 2, 3, output word i equals input word i XOR output word i-1.
- R5: The rotation moves each byte of the substituted word one byte toward the top, and the first byte wraps to the last position: {b0,b1,b2,b3} becomes {b1,b2,b3,b0}.
- R6: Byte substitution is the AES S-box: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0 maps to 0), followed by the affine map with constant 0x63. Applying the block ten times to the key 2b7e151628aed2a6abf7158809cf4f3c, with round constants 01,02,04,08,10,20,40,80,1b,36, yields d014f9a8c9ee2589e13f0cc8b6630ca6.
- R7: Keys offered on consecutive cycles are all accepted, and their results leave on consecutive cycles in the same order.
- R8: An input cycle with `in_valid` low produces `out_valid` low three edges later.
- R9: The round constant is XORed into bits [31:24] of the transformed word only. A constant of 0x00 leaves that word as the plain rotated substitution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears the valid flags |
| in_valid | input | 1 | Current key and constant are meaningful this cycle |
| in_key | input | 128 | Current round key, word 0 in the top bits |
| in_rcon | input | 8 | Round constant for this step |
| out_valid | output | 1 | `out_key` holds a finished key |
| out_key | output | 128 | Next round key |

## Verification
Every result is due exactly three rising edges after its input is captured. The valid flag follows the same three-edge latency, whether it is high or low. The bench keeps a behavioural model that computes each expected key when the input is driven, and places it in a queue that stays three entries deep. On each falling edge it pops the oldest entry and compares it with the outputs, which settled at the preceding rising edge. A reset empties the queue and refills it with three invalid entries, so results that were in flight are expected to vanish. The ten-round chain is run by feeding each output back into the input three cycles after the key was driven, and the final key is compared with the published value.

// File: rtl/aes_key_pkg.sv
package aes_key_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int KEY_WORDS  = 4;
    localparam int KEY_W      = WORD_W * KEY_WORDS;
    localparam logic [BYTE_W-1:0] GF_POLY_LOW = 8'h1B;
    localparam logic [BYTE_W-1:0] AFFINE_C    = 8'h63;
    localparam logic [BYTE_W-1:0] INV_EXP     = 8'd254;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [KEY_W-1:0]  key_t;

    // GF(2^8) product, shift-and-add with reduction
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[BYTE_W-1] ? ((sh << 1) ^ GF_POLY_LOW) : (sh << 1);
        end
        return acc;
    endfunction

    // Inverse as a^254 by square-and-multiply; 0 maps to 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r;
        r = 8'h01;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (INV_EXP[i]) r = gf_mul(r, a);
        end
        return r;
    endfunction

    function automatic byte_t rotl_byte(input byte_t b, input int n);
        return byte_t'((b << n) | (b >> (BYTE_W - n)));
    endfunction

    function automatic word_t key_word(input key_t k, input int idx);
        return k[KEY_W-1-idx*WORD_W -: WORD_W];
    endfunction

endpackage

// File: rtl/aes_sbox_byte.sv
module aes_sbox_byte
    import aes_key_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    byte_t inv;

    always_comb begin
        inv  = gf_inv(din);
        dout = inv ^ rotl_byte(inv, 1) ^ rotl_byte(inv, 2)
                   ^ rotl_byte(inv, 3) ^ rotl_byte(inv, 4) ^ AFFINE_C;
    end
endmodule

// File: rtl/key_sub_stage.sv
module key_sub_stage
    import aes_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [BYTE_W-1:0] in_rcon,
    output logic              sub_valid,
    output logic [KEY_W-1:0]  sub_key,
    output logic [BYTE_W-1:0] sub_rcon,
    output logic [WORD_W-1:0] sub_word
);
    localparam int LAST = KEY_WORDS - 1;

    word_t last_word;
    word_t subst_word;

    assign last_word = key_word(in_key, LAST);

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_sbox
        aes_sbox_byte u_sbox (
            .din  (last_word[g*BYTE_W +: BYTE_W]),
            .dout (subst_word[g*BYTE_W +: BYTE_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_valid <= 1'b0;
        else        sub_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        sub_key  <= in_key;
        sub_rcon <= in_rcon;
        sub_word <= subst_word;
    end
endmodule

// File: rtl/key_rot_stage.sv
module key_rot_stage
    import aes_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_valid,
    input  logic [KEY_W-1:0]  sub_key,
    input  logic [BYTE_W-1:0] sub_rcon,
    input  logic [WORD_W-1:0] sub_word,
    output logic              rot_valid,
    output logic [KEY_W-1:0]  rot_key,
    output logic [WORD_W-1:0] rot_word
);
    word_t rotated;
    word_t with_rc;

    always_comb begin
        rotated = {sub_word[WORD_W-BYTE_W-1:0], sub_word[WORD_W-1 -: BYTE_W]};
        with_rc = rotated ^ {sub_rcon, {(WORD_W-BYTE_W){1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rot_valid <= 1'b0;
        else        rot_valid <= sub_valid;
    end

    always_ff @(posedge clk) begin
        rot_key  <= sub_key;
        rot_word <= with_rc;
    end
endmodule

// File: rtl/key_xor_stage.sv
module key_xor_stage
    import aes_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rot_valid,
    input  logic [KEY_W-1:0]  rot_key,
    input  logic [WORD_W-1:0] rot_word,
    output logic              xor_valid,
    output logic [KEY_W-1:0]  xor_key
);
    word_t chain [KEY_WORDS];
    key_t  next_key;

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_chain
        if (g == 0) begin : g_head
            assign chain[g] = key_word(rot_key, g) ^ rot_word;
        end else begin : g_link
            assign chain[g] = key_word(rot_key, g) ^ chain[g-1];
        end
        assign next_key[KEY_W-1-g*WORD_W -: WORD_W] = chain[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xor_valid <= 1'b0;
        else        xor_valid <= rot_valid;
    end

    always_ff @(posedge clk) begin
        xor_key <= next_key;
    end
endmodule

// File: rtl/aes128_key_step.sv
module aes128_key_step
    import aes_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [BYTE_W-1:0] in_rcon,
    output logic              out_valid,
    output logic [KEY_W-1:0]  out_key
);
    logic              sub_valid;
    logic [KEY_W-1:0]  sub_key;
    logic [BYTE_W-1:0] sub_rcon;
    logic [WORD_W-1:0] sub_word;
    logic              rot_valid;
    logic [KEY_W-1:0]  rot_key;
    logic [WORD_W-1:0] rot_word;

    key_sub_stage u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_key    (in_key),
        .in_rcon   (in_rcon),
        .sub_valid (sub_valid),
        .sub_key   (sub_key),
        .sub_rcon  (sub_rcon),
        .sub_word  (sub_word)
    );

    key_rot_stage u_rot (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_valid (sub_valid),
        .sub_key   (sub_key),
        .sub_rcon  (sub_rcon),
        .sub_word  (sub_word),
        .rot_valid (rot_valid),
        .rot_key   (rot_key),
        .rot_word  (rot_word)
    );

    key_xor_stage u_xor (
        .clk       (clk),
        .rst_n     (rst_n),
        .rot_valid (rot_valid),
        .rot_key   (rot_key),
        .rot_word  (rot_word),
        .xor_valid (out_valid),
        .xor_key   (out_key)
    );
endmodule

// File: rtl/aes128_key_step_chk.sv
module aes128_key_step_chk
    import aes_key_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [KEY_W-1:0]  in_key,
    input logic              out_valid,
    input logic [KEY_W-1:0]  out_key
);
    // R1: reset holds the output flag low
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> !out_valid);

    // R2 / R7: every accepted key leaves three edges later
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R8: an empty slot stays empty
    assert_bubble_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R4: chained words relate to the input captured three edges earlier
    assert_xor_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |->
            ((out_key[95:64] ^ out_key[127:96]) == $past(in_key[95:64], 3)) &&
            ((out_key[63:32] ^ out_key[95:64])  == $past(in_key[63:32], 3)) &&
            ((out_key[31:0]  ^ out_key[63:32])  == $past(in_key[31:0], 3)));
endmodule

bind aes128_key_step aes128_key_step_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_key    (in_key),
    .out_valid (out_valid),
    .out_key   (out_key)
);

// File: tb/aes128_key_step_tb.sv
module aes128_key_step_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_key = '0;
    logic [7:0]   in_rcon = '0;
    logic         out_valid;
    logic [127:0] out_key;

    int checks = 0;
    int errors = 0;

    logic [128:0] exp_q [$];
    string        tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    aes128_key_step u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_key    (in_key),
        .in_rcon   (in_rcon),
        .out_valid (out_valid),
        .out_key   (out_key)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        int p = 0;
        int x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x << 1;
            if (x > 255) x = x ^ 'h11B;
        end
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] a);
        logic [7:0] inv = 8'h00;
        logic [7:0] r;
        logic [7:0] c = 8'h63;
        for (int y = 1; y < 256; y++)
            if (a != 0 && m_mul(a, y[7:0]) == 8'h01) inv = y[7:0];
        for (int i = 0; i < 8; i++)
            r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return r;
    endfunction

    function automatic logic [127:0] m_next(input logic [127:0] k, input logic [7:0] rc);
        logic [31:0] w [4];
        logic [7:0]  b [4];
        logic [31:0] t;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 0; i < 4; i++) b[i] = m_sbox(w[3][31-8*i -: 8]);
        t = {b[1] ^ rc, b[2], b[3], b[0]};
        w[0] = w[0] ^ t;
        for (int i = 1; i < 4; i++) w[i] = w[i] ^ w[i-1];
        return {w[0], w[1], w[2], w[3]};
    endfunction

    // ---------------- per-cycle compare and drive ----------------
    task automatic compare_out();
        logic [128:0] e;
        string        tg;
        if (exp_q.size() == 3) begin
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (out_valid !== e[128] || (e[128] && out_key !== e[127:0])) begin
                errors++;
                $display("FAIL %s: valid=%0b key=%h expected valid=%0b key=%h",
                         tg, out_valid, out_key, e[128], e[127:0]);
            end
        end
    endtask

    task automatic step(input logic v, input logic [127:0] k, input logic [7:0] rc,
                        input string tg);
        @(negedge clk);
        compare_out();
        in_valid = v;
        in_key   = k;
        in_rcon  = rc;
        exp_q.push_back({v, m_next(k, rc)});
        tag_q.push_back(tg);
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        exp_q.delete();
        tag_q.delete();
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1: valid=%0b expected valid=0 during reset", out_valid);
            end
        end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back({1'b0, 128'h0});
            tag_q.push_back("R1");
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(1'b0, '0, 8'h00, "R8");
    endtask

    localparam logic [127:0] FIPS_KEY   = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] FIPS_R1    = 128'ha0fafe1788542cb123a339392a6c7605;
    localparam logic [127:0] FIPS_LAST  = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

    initial begin
        logic [7:0]   rcs [10];
        logic [127:0] k;
        rcs = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};

        do_reset(3);
        // R1: idle output right after reset
        step(1'b0, '0, 8'h00, "R1");
        step(1'b0, '0, 8'h00, "R1");

        // R3 R5 R6: first round of the published vector
        step(1'b1, FIPS_KEY, 8'h01, "R3");
        drain();
        checks++;
        if (m_next(FIPS_KEY, 8'h01) !== FIPS_R1) begin
            errors++;
            $display("FAIL R6: model=%h expected=%h", m_next(FIPS_KEY, 8'h01), FIPS_R1);
        end

        // R9: zero, full and top constants
        step(1'b1, 128'h00112233445566778899aabbccddeeff, 8'h00, "R9");
        step(1'b1, 128'h00112233445566778899aabbccddeeff, 8'hff, "R9");
        step(1'b1, 128'h00112233445566778899aabbccddeeff, 8'h36, "R9");
        // R5: distinct bytes in the last word expose rotation direction
        step(1'b1, 128'h000000000000000000000000_01020304, 8'h00, "R5");
        step(1'b1, '1, 8'h1b, "R4");
        step(1'b1, '0, 8'h00, "R6");
        drain();

        // R7: back-to-back random keys
        for (int i = 0; i < 40; i++)
            step(1'b1, {$urandom, $urandom, $urandom, $urandom}, 8'($urandom), "R7");
        // R8: sparse pattern with bubbles
        for (int i = 0; i < 40; i++)
            step(1'($urandom % 2), {$urandom, $urandom, $urandom, $urandom},
                 8'($urandom), "R8");
        // R2: single key isolated by bubbles
        step(1'b1, {$urandom, $urandom, $urandom, $urandom}, 8'h80, "R2");
        drain();

        // R1: reset during a burst discards in-flight keys
        for (int i = 0; i < 2; i++)
            step(1'b1, {$urandom, $urandom, $urandom, $urandom}, 8'h04, "R7");
        do_reset(2);
        step(1'b0, '0, 8'h00, "R1");
        step(1'b1, FIPS_KEY, 8'h01, "R2");
        drain();

        // R6: ten rounds fed back through the design
        k = FIPS_KEY;
        for (int r = 0; r < 10; r++) begin
            step(1'b1, k, rcs[r], "R6");
            for (int j = 0; j < 3; j++) step(1'b0, '0, 8'h00, "R6");
            k = out_key;
        end
        checks++;
        if (k !== FIPS_LAST) begin
            errors++;
            $display("FAIL R6: key=%h expected=%h", k, FIPS_LAST);
        end
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: cycles=%0d expected completion", WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule